// File: doc/BRIEF.md
# Dual-Gain Sample Selector with DDR Serial Output

Each conversion period a calorimeter front end produces three 12-bit codes (0 to 4095) for the same pulse: one from a high-gain path, one from a medium-gain path and one from a low-gain path. The gain steps are roughly eight, so the high-gain path clips first. This block takes one set of three codes per handshake and builds a 26-bit frame. The frame always carries the medium-gain code. It also carries either the high-gain code or the low-gain code, with a one-bit tag that records which one was kept. The frame leaves on a group of serial lanes that send two bits per lane in each clock cycle, one in the high phase and one in the low phase.

The high-gain code is kept while it is below a programmable clip threshold. When it reaches the threshold, the low-gain code replaces it. An asynchronous force pin makes the block send low gain whatever the high-gain value is. A frame marker shows the start of each frame.

The sample input is a valid/ready stream. A set is taken on a clock edge where `in_valid` and `in_ready` are both high. While a frame is still being sent, `in_ready` stays low. It rises again in the last clock cycle of the frame, so frames can follow each other with no gap. With 13 lanes a frame fits in one cycle and `in_ready` never drops. The producer must hold its set while `in_ready` is low. The block never stalls its serial side.

Top module: `gain_sel_ser`

## Requirements
- R1: While `rst_n` is low and until the first accepted set, all lanes and `frame_mark` are 0 and `in_ready` is 1. The clip threshold resets to 4000.
- R2: Frame bits 24..13 carry the medium-gain code of the accepted set, MSB at bit 24. The frame is numbered 25 (sent first) down to 0.
- R3: When the force pin is not in effect and the high-gain code is below the threshold, bit 25 (tag) is 0 and bits 12..1 carry the high-gain code.
- R4: When the high-gain code is equal to or above the threshold, the tag is 1 and bits 12..1 carry the low-gain code.
- R5: A cycle with `thr_load` high writes `thr_value` into the threshold. The new threshold applies to sets accepted on later edges.
- R6: `force_low` passes through two flip-flops. Once it is in effect at an accepted set, that frame has tag 1 and the low-gain code. Because the choice is made once per frame, no frame ever mixes the two choices.
- R7: Bit 0 is the XOR of bits 25..1, so each frame has an even count of ones.
- R8: Slot s of a frame holds frame bit 25−s, and slots 26 and above are 0. In frame cycle c, lane l sends slot 2·L·c+l during the high clock phase and slot 2·L·c+L+l during the low phase.
- R9: `frame_mark` is high only during the high phase of the first cycle of each frame.
- R10: `in_ready` is low in every cycle of a frame except the last one. A set offered while `in_ready` is low is ignored, and the frame in progress continues unchanged.
- R11: When no frame is being sent, all lanes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one edge per conversion period |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample set offered |
| in_ready | output | 1 | Block can take a set on this edge |
| hi_sample | input | 12 | High-gain code |
| mid_sample | input | 12 | Medium-gain code |
| lo_sample | input | 12 | Low-gain code |
| thr_load | input | 1 | Write `thr_value` into the clip threshold |
| thr_value | input | 12 | New clip threshold |
| force_low | input | 1 | Asynchronous request to send low gain |
| lane_o | output | NUM_LANES | Serial lanes, high phase then low phase |
| frame_mark | output | 1 | Frame start marker |

## Verification
The bench builds the block with `NUM_LANES` = 4 instead of the default 13. At that width a frame spans four clock cycles with six padding slots at the end, so the bench can reach these cases:
- back-pressure, where `in_ready` is low for three cycles;
- offers that are ignored while a frame is in progress;
- the padding slots and the cycle-by-cycle lane order.

Threshold codes at the limit (3999, 4000, 4095) are driven, both at the reset value and after a new threshold is loaded. The force pin is toggled close to accept edges, which exercises the two-stage delay.

// File: rtl/gain_sel_pkg.sv
package gain_sel_pkg;
  typedef enum logic {
    PICK_HIGH = 1'b0,
    PICK_LOW  = 1'b1
  } pick_t;

  function automatic int frame_bits(input int sample_w);
    return 2 * sample_w + 2;
  endfunction

  function automatic int frame_cycles(input int sample_w, input int lanes);
    return (frame_bits(sample_w) + 2 * lanes - 1) / (2 * lanes);
  endfunction
endpackage

// File: rtl/gain_sync.sv
module gain_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], async_in};
  end

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/gain_pick.sv
module gain_pick
  import gain_sel_pkg::*;
#(
  parameter int SAMPLE_W = 12
) (
  input  logic [SAMPLE_W-1:0] hi_code,
  input  logic [SAMPLE_W-1:0] lo_code,
  input  logic [SAMPLE_W-1:0] clip_thr,
  input  logic                force_sel,
  output pick_t               pick,
  output logic [SAMPLE_W-1:0] picked_code
);
  always_comb begin
    if (force_sel || (hi_code >= clip_thr)) begin
      pick        = PICK_LOW;
      picked_code = lo_code;
    end else begin
      pick        = PICK_HIGH;
      picked_code = hi_code;
    end
  end
endmodule

// File: rtl/frame_pack.sv
module frame_pack
  import gain_sel_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  localparam int FB = 2 * SAMPLE_W + 2
) (
  input  pick_t               pick,
  input  logic [SAMPLE_W-1:0] mid_code,
  input  logic [SAMPLE_W-1:0] picked_code,
  output logic [FB-1:0]       frame
);
  logic [FB-2:0] body;

  assign body  = {logic'(pick), mid_code, picked_code};
  assign frame = {body, ^body};
endmodule

// File: rtl/ddr_lane_ser.sv
module ddr_lane_ser #(
  parameter int FB    = 26,
  parameter int LANES = 13,
  localparam int CYC   = (FB + 2 * LANES - 1) / (2 * LANES),
  localparam int SLOTS = 2 * LANES * CYC,
  localparam int CNT_W = (CYC > 1) ? $clog2(CYC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [FB-1:0]    frame_in,
  output logic             ready,
  output logic             active_q,
  output logic             start_q,
  output logic [SLOTS-1:0] slots_q,
  output logic [LANES-1:0] rise_bits,
  output logic [LANES-1:0] fall_bits
);
  logic [CNT_W-1:0] cyc_q;
  logic             last;

  assign last  = (cyc_q == CNT_W'(CYC - 1));
  assign ready = !active_q || last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slots_q  <= '0;
      active_q <= 1'b0;
      start_q  <= 1'b0;
      cyc_q    <= '0;
    end else if (load) begin
      slots_q  <= SLOTS'(frame_in) << (SLOTS - FB);
      active_q <= 1'b1;
      start_q  <= 1'b1;
      cyc_q    <= '0;
    end else begin
      start_q <= 1'b0;
      if (active_q) begin
        if (last) begin
          slots_q  <= '0;
          active_q <= 1'b0;
          cyc_q    <= '0;
        end else begin
          slots_q <= slots_q << (2 * LANES);
          cyc_q   <= cyc_q + 1'b1;
        end
      end
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign rise_bits[l] = slots_q[SLOTS-1-l];
    assign fall_bits[l] = slots_q[SLOTS-1-LANES-l];
  end
endmodule

// File: rtl/gain_sel_ser.sv
module gain_sel_ser
  import gain_sel_pkg::*;
#(
  parameter int SAMPLE_W  = 12,
  parameter int NUM_LANES = 13,
  parameter int THR_RESET = 4000,
  localparam int FB    = 2 * SAMPLE_W + 2,
  localparam int CYC   = (FB + 2 * NUM_LANES - 1) / (2 * NUM_LANES),
  localparam int SLOTS = 2 * NUM_LANES * CYC
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [SAMPLE_W-1:0]  hi_sample,
  input  logic [SAMPLE_W-1:0]  mid_sample,
  input  logic [SAMPLE_W-1:0]  lo_sample,
  input  logic                 thr_load,
  input  logic [SAMPLE_W-1:0]  thr_value,
  input  logic                 force_low,
  output logic [NUM_LANES-1:0] lane_o,
  output logic                 frame_mark
);
  logic [SAMPLE_W-1:0]  thr_q;
  logic                 force_s;
  pick_t                pick;
  logic [SAMPLE_W-1:0]  picked_code;
  logic [FB-1:0]        frame;
  logic                 accept;
  logic                 active_q;
  logic                 start_q;
  logic [SLOTS-1:0]     slots_q;
  logic [NUM_LANES-1:0] rise_bits;
  logic [NUM_LANES-1:0] fall_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        thr_q <= SAMPLE_W'(THR_RESET);
    else if (thr_load) thr_q <= thr_value;
  end

  gain_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(force_low), .sync_out(force_s)
  );

  gain_pick #(.SAMPLE_W(SAMPLE_W)) u_pick (
    .hi_code(hi_sample), .lo_code(lo_sample), .clip_thr(thr_q),
    .force_sel(force_s), .pick(pick), .picked_code(picked_code)
  );

  frame_pack #(.SAMPLE_W(SAMPLE_W)) u_pack (
    .pick(pick), .mid_code(mid_sample), .picked_code(picked_code), .frame(frame)
  );

  assign accept = in_valid && in_ready;

  ddr_lane_ser #(.FB(FB), .LANES(NUM_LANES)) u_ser (
    .clk(clk), .rst_n(rst_n), .load(accept), .frame_in(frame),
    .ready(in_ready), .active_q(active_q), .start_q(start_q),
    .slots_q(slots_q), .rise_bits(rise_bits), .fall_bits(fall_bits)
  );

  assign lane_o     = clk ? rise_bits : fall_bits;
  assign frame_mark = clk & start_q;
endmodule

// File: rtl/gain_sel_ser_chk.sv
module gain_sel_ser_chk #(
  parameter int SLOTS = 26,
  parameter int CYC   = 1,
  parameter int LANES = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             force_s,
  input logic             active_q,
  input logic             start_q,
  input logic [SLOTS-1:0] slots_q,
  input logic [LANES-1:0] rise_bits,
  input logic [LANES-1:0] fall_bits
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !active_q);

  // R6
  force_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && force_s) |=> slots_q[SLOTS-1]);

  // R7
  parity_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> ($countones(slots_q) % 2 == 0));

  // R9
  mark_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (start_q && active_q));

  // R10
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (CYC > 1)) |=> !in_ready);

  // R11
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |-> (rise_bits == '0 && fall_bits == '0));
endmodule

bind gain_sel_ser gain_sel_ser_chk #(.SLOTS(SLOTS), .CYC(CYC), .LANES(NUM_LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .force_s(force_s), .active_q(active_q), .start_q(start_q),
  .slots_q(slots_q), .rise_bits(rise_bits), .fall_bits(fall_bits)
);

// File: tb/gain_sel_ser_tb_top.sv
module gain_sel_ser_tb_top;
  localparam int L   = 4;
  localparam int CYC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [11:0] hi_sample = '0, mid_sample = '0, lo_sample = '0;
  logic        thr_load = 1'b0;
  logic [11:0] thr_value = '0;
  logic        force_low = 1'b0;
  logic [L-1:0] lane_o;
  logic        frame_mark;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  gain_sel_ser #(.NUM_LANES(L)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .hi_sample(hi_sample), .mid_sample(mid_sample), .lo_sample(lo_sample),
    .thr_load(thr_load), .thr_value(thr_value), .force_low(force_low),
    .lane_o(lane_o), .frame_mark(frame_mark)
  );

  // behavioural reference
  bit          m_act = 0;
  int          m_cyc = 0;
  logic [25:0] m_frame = '0;
  int          m_thr = 4000;
  bit          m_f1 = 0, m_f2 = 0;

  function automatic logic [25:0] mk_frame(input bit tag, input logic [11:0] m, input logic [11:0] s);
    logic [24:0] b;
    b = {tag, m, s};
    return {b, ^b};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_cyc = 0; m_frame = '0; m_thr = 4000; m_f1 = 0; m_f2 = 0;
    end else begin
      bit rdy;
      rdy = !m_act || (m_cyc == CYC - 1);
      if (in_valid && rdy) begin
        if (m_f2 || int'(hi_sample) >= m_thr) m_frame = mk_frame(1'b1, mid_sample, lo_sample);
        else                                 m_frame = mk_frame(1'b0, mid_sample, hi_sample);
        m_act = 1; m_cyc = 0;
      end else if (m_act) begin
        if (m_cyc == CYC - 1) begin m_act = 0; m_cyc = 0; end
        else m_cyc++;
      end
      if (thr_load) m_thr = int'(thr_value);
      m_f2 = m_f1; m_f1 = force_low;
    end
  end

  function automatic bit exp_slot(input int s);
    if (!m_act || s >= 26) return 1'b0;
    return m_frame[25 - s];
  endfunction

  function automatic string req_of(input int s);
    if (!rst_n) return "R1";
    if (!m_act) return "R11";
    if (s == 0) return "R3/R4/R5/R6";
    if (s <= 12) return "R2";
    if (s <= 24) return "R3/R4";
    if (s == 25) return "R7";
    return "R8";
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  // sampling: high phase at +2, low phase at +7 after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      for (int l = 0; l < L; l++)
        chk(req_of(m_cyc*2*L + l), $sformatf("R8 hi lane%0d", l), int'(lane_o[l]), int'(exp_slot(m_cyc*2*L + l)));
      chk(rst_n ? "R9" : "R1", "mark hi", int'(frame_mark), int'(m_act && m_cyc == 0));
      chk(rst_n ? "R10" : "R1", "ready", int'(in_ready), int'(!m_act || m_cyc == CYC - 1));
      #5;
      for (int l = 0; l < L; l++)
        chk(req_of(m_cyc*2*L + L + l), $sformatf("R8 lo lane%0d", l), int'(lane_o[l]), int'(exp_slot(m_cyc*2*L + L + l)));
      chk("R9", "mark lo", int'(frame_mark), 0);
    end
  end

  task automatic drive(input bit v, input int hi, input int mid, input int lo);
    @(posedge clk); #8;
    in_valid = v; hi_sample = 12'(hi); mid_sample = 12'(mid); lo_sample = 12'(lo);
    thr_load = 1'b0;
  endtask

  // hold an offer until accepted (ready sampled in high phase before the edge)
  task automatic send(input int hi, input int mid, input int lo);
    drive(1'b1, hi, mid, lo);
    while (!(m_act == 0 || m_cyc == CYC - 1)) drive(1'b1, hi, mid, lo);
  endtask

  initial begin
    int seed;
    seed = 7;
    repeat (3) @(posedge clk);
    #8 rst_n = 1'b1;
    repeat (3) drive(1'b0, 0, 0, 0);                // R11 idle
    send(100, 2048, 7);                             // R3
    send(3999, 1234, 500);                          // R3 below threshold
    send(4000, 4095, 501);                          // R4 at threshold
    send(4095, 0, 4095);                            // R4
    drive(1'b0, 0, 0, 0);
    @(posedge clk); #8 thr_load = 1'b1; thr_value = 12'd2000; // R5
    send(1999, 77, 88);
    send(2000, 77, 88);
    drive(1'b1, 3000, 5, 6);                        // R10 offers during busy
    drive(1'b1, 10, 11, 12);
    drive(1'b0, 0, 0, 0);
    @(posedge clk); #8 force_low = 1'b1;            // R6
    send(5, 6, 7);
    send(5, 6, 7);
    force_low = 1'b0;
    send(5, 6, 7);
    send(5, 6, 7);
    for (int i = 0; i < 300; i++) begin
      seed = seed * 1103515245 + 12345;
      force_low = seed[20];
      drive(seed[17] | seed[9], seed[27:16], seed[11:0], seed[30:19]);
    end
    drive(1'b0, 0, 0, 0);
    repeat (6) @(posedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (100000) @(posedge clk); fails++; checks++; $display("FAIL watchdog expired"); end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule